// File: doc/BRIEF.md
# Keyed Software Watchdog

This block is a software watchdog timer driven by a small register bus. A byte-wide control register sets the enable, the expiry action, a prescaler and a timeout select. A service register accepts a two-byte key. Software must write the first key byte and then the second key byte, back to back, before the timer expires. If it does not, the block either raises an interrupt request that stays up until it is acknowledged, or emits a one-cycle soft-reset pulse.

Timeouts are powers of two of the clock period and cover two ranges. The prescaler divides the clock by a fixed power of two. A newly written period setting is only staged in the control register. It becomes the running period when the next complete key service is accepted, so a stray control write cannot shorten the interval under running software.

The register bus is a plain single-cycle write port with a combinational read. It has no valid/ready handshake and no back-pressure: every write is taken in the cycle it is presented.

Top module: `kwdt_top`

## Requirements
- R1: The control register sits at address 0 and reads back combinationally. Its fields are: bit 7 enable, bit 6 action (0 interrupt, 1 soft reset), bit 5 prescaler on, bits 4:3 timeout select, bits 2:0 spare. It resets to 0x00. Address 1 is the service register, which reads as 0x00.
- R2: A write of 0x55 to the service register followed by a write of 0xAA on the next service write is a complete service. It clears the counter and the prescaler in the cycle of the 0xAA write.
- R3: After 0x55, any service write other than 0xAA returns the key detector to idle and leaves the counter running uncleared.
- R4: With the prescaler off, the running period is 2^(BASE_LOG2 + STEP_LOG2*select) clock cycles (by default 2^9, 2^11, 2^13 and 2^15). Expiry is registered exactly that many rising edges after the enabling write or the completing service write.
- R5: With the prescaler on, the running period is multiplied by 2^PRE_LOG2 (by default 8192, giving 2^22 to 2^28 cycles).
- R6: The prescaler and select bits only become the running period when a complete service is accepted. After system reset or soft reset, the running period is the shortest unprescaled one.
- R7: In interrupt mode, irq rises at expiry and stays high until a cycle with irq_ack high clears it. Counting is halted at zero while irq is high.
- R8: In soft-reset mode, soft_reset is high for exactly one cycle at expiry. In that same edge the control register returns to 0x00, the key detector returns to idle and the running period returns to the shortest unprescaled one.
- R9: Control register writes are ignored while irq is high.
- R10: While enable is 0 the counter is held at zero. Setting enable again counts a full running period from the enabling write.
- R11: Bits 2:0 of the control register are stored and read back unchanged and do not affect timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_addr | input | ADDR_W | Register address (0 control, 1 service) |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_ack | input | 1 | Clears a pending interrupt request |
| irq | output | 1 | Watchdog interrupt request, level |
| soft_reset | output | 1 | One-cycle soft-reset pulse on expiry |

## Verification
Almost every internal fault in this block shows up as a shift in when irq or soft_reset rises. A counter that misses a clear, a key detector stuck armed, or a running period taken from the control register too early all move the expiry edge. The bench therefore measures the distance in cycles from the enabling or servicing write to the event and compares it with the exact period. A lock or clear fault is visible at the very next read of the control register, and a held interrupt that drops early is visible within a cycle.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int CTRL_ADDR = 0;
  localparam int SVC_ADDR  = 1;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;

  typedef struct packed {
    logic       en;
    logic       rst_mode;
    logic       pre;
    logic [1:0] sel;
    logic [2:0] spare;
  } ctrl_t;

  typedef struct packed {
    logic       pre;
    logic [1:0] sel;
  } period_t;

endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       svc_done
);

  key_state_e state_q;

  always_comb begin
    svc_done = wr && (state_q == KEY_ARMED) && (wdata == KEY_SECOND);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      state_q <= KEY_IDLE;
    end else if (wr) begin
      if (state_q == KEY_IDLE && wdata == KEY_FIRST) begin
        state_q <= KEY_ARMED;
      end else begin
        state_q <= KEY_IDLE;
      end
    end
  end

  // R2: a completed service leaves the detector idle for the next pair
  a_r2_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> (state_q == KEY_IDLE));

  // R3: a non-key write never leaves the detector armed
  a_r3_bad_key_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata != KEY_FIRST) |=> (state_q == KEY_IDLE));

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ctrl_wr,
  input  logic [7:0] wdata,
  input  logic       locked,
  input  logic       svc_done,
  output ctrl_t      ctrl_q,
  output period_t    active_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ctrl_q <= '0;
    end else if (ctrl_wr && !locked) begin
      ctrl_q <= ctrl_t'(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      active_q <= '0;
    end else if (svc_done) begin
      active_q <= '{pre: ctrl_q.pre, sel: ctrl_q.sel};
    end
  end

  // R9: control register frozen while an interrupt is pending
  a_r9_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ctrl_q));

  // R6: running period changes only on service or soft reset
  a_r6_active_on_service: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_done && !clr) |=> $stable(active_q));

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int BASE_LOG2 = 9,
  parameter int PRE_LOG2  = 13,
  parameter int STEP_LOG2 = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    restart,
  input  period_t period,
  output logic    expire
);

  localparam int MAX_EXP = BASE_LOG2 + 3 * STEP_LOG2;
  localparam int CNT_W   = MAX_EXP + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] limit;
  logic             tick;
  logic             wipe;
  int               shamt;

  always_comb begin
    shamt = BASE_LOG2 + STEP_LOG2 * int'(period.sel);
    span  = {{(CNT_W-1){1'b0}}, 1'b1} << shamt;
    limit = span - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  generate
    if (PRE_LOG2 == 0) begin : g_no_pre
      always_comb tick = 1'b1;
    end else begin : g_pre
      logic [PRE_LOG2-1:0] pre_q;

      always_comb tick = period.pre ? (&pre_q) : 1'b1;

      always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end

      // R5: with the prescaler on, the main count moves only on a divider wrap
      a_r5_pre_gates_count: assert property (@(posedge clk) disable iff (!rst_n)
        (run && period.pre && !(&pre_q) && !restart) |=> $stable(cnt_q));
    end
  endgenerate

  always_comb begin
    expire = run && !restart && tick && (cnt_q == limit);
    wipe   = !run || restart || expire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the count never passes the running period's last value
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R10: a stopped counter sits at zero on the next cycle
  a_r10_stop_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> (cnt_q == '0));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W    = 1,
  parameter int BASE_LOG2 = 9,
  parameter int PRE_LOG2  = 13,
  parameter int STEP_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              irq_ack,
  output logic              irq,
  output logic              soft_reset
);

  logic    ctrl_wr;
  logic    svc_wr;
  logic    svc_done;
  logic    expire;
  logic    clr;
  logic    run;
  logic    irq_q;
  logic    soft_q;
  ctrl_t   ctrl_q;
  period_t active_q;

  always_comb begin
    ctrl_wr   = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
    svc_wr    = bus_we && (bus_addr == ADDR_W'(SVC_ADDR));
    clr       = expire && ctrl_q.rst_mode;
    run       = ctrl_q.en && !irq_q;
    bus_rdata = (bus_addr == ADDR_W'(CTRL_ADDR)) ? 8'(ctrl_q) : 8'h00;
  end

  kwdt_keyseq u_keyseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .wr       (svc_wr),
    .wdata    (bus_wdata),
    .svc_done (svc_done)
  );

  kwdt_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .ctrl_wr  (ctrl_wr),
    .wdata    (bus_wdata),
    .locked   (irq_q),
    .svc_done (svc_done),
    .ctrl_q   (ctrl_q),
    .active_q (active_q)
  );

  kwdt_counter #(
    .BASE_LOG2 (BASE_LOG2),
    .PRE_LOG2  (PRE_LOG2),
    .STEP_LOG2 (STEP_LOG2)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (svc_done),
    .period  (active_q),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (expire && !ctrl_q.rst_mode) begin
      irq_q <= 1'b1;
    end else if (irq_ack) begin
      irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_q <= 1'b0;
    end else begin
      soft_q <= clr;
    end
  end

  assign irq        = irq_q;
  assign soft_reset = soft_q;

  // R7: a pending request stays up until acknowledged
  a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack) |=> irq_q);

  // R8: the soft-reset pulse lasts a single cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |=> !soft_q);

  // R8: the control register is already cleared while the pulse is out
  a_r8_ctrl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |-> (ctrl_q == '0));

  // R7: both expiry actions never show at once
  a_r7_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_q && soft_q));

endmodule

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;

  localparam int BASE = 4;
  localparam int PRE  = 3;
  localparam int STEP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [0:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic       soft_reset;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  kwdt_top #(
    .ADDR_W    (1),
    .BASE_LOG2 (BASE),
    .PRE_LOG2  (PRE),
    .STEP_LOG2 (STEP)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_ack    (irq_ack),
    .irq        (irq),
    .soft_reset (soft_reset)
  );

  function automatic int period_of(bit pre, int sel);
    return 1 << (BASE + STEP * sel + (pre ? PRE : 0));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(logic [0:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic read_reg(logic [0:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic do_ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(posedge clk); #1;
    irq_ack = 1'b0;
  endtask

  task automatic service();
    bus_wr(1'b1, 8'h55);
    bus_wr(1'b1, 8'hAA);
  endtask

  task automatic wait_event(int limit, output int n, output bit got_irq, output bit got_rst);
    n = 0; got_irq = 1'b0; got_rst = 1'b0;
    while (n < limit) begin
      @(posedge clk); #1;
      n++;
      if (irq || soft_reset) begin
        got_irq = irq; got_rst = soft_reset;
        break;
      end
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    bit gi, gr;
    void'($urandom(32'd2718));

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    read_reg(1'b0, v);
    check(v == 8'h00, "R1", "ctrl after reset", v, 0);
    check(!irq && !soft_reset, "R1", "outputs after reset", {irq, soft_reset}, 0);
    read_reg(1'b1, v);
    check(v == 8'h00, "R1", "service reads zero", v, 0);

    // R6 staged select ignored before a service: shortest period runs
    bus_wr(1'b0, 8'h98);
    wait_event(5000, n, gi, gr);
    check(gi && n == period_of(0, 0), "R6", "first period before service", n, period_of(0, 0));

    // R7 held until ack
    repeat (5) @(posedge clk);
    #1 check(irq == 1'b1, "R7", "irq held without ack", irq, 1);

    // R9 locked while pending
    bus_wr(1'b0, 8'h00);
    read_reg(1'b0, v);
    check(v == 8'h98, "R9", "ctrl write while pending", v, 8'h98);

    do_ack();
    check(irq == 1'b0, "R7", "irq cleared by ack", irq, 0);

    // R2 R4 service applies the staged select 11
    service();
    wait_event(5000, n, gi, gr);
    check(gi && n == period_of(0, 3), "R2", "period after service", n, period_of(0, 3));

    // back to select 00
    do_ack();
    bus_wr(1'b0, 8'h80);
    service();
    wait_event(5000, n, gi, gr);
    check(gi && n == period_of(0, 0), "R4", "shortest period after service", n, period_of(0, 0));

    // R3 broken key does not clear
    do_ack();
    service();
    bus_wr(1'b1, 8'h55);
    bus_wr(1'b1, 8'h13);
    bus_wr(1'b1, 8'hAA);
    wait_event(5000, n, gi, gr);
    check(gi && n == period_of(0, 0) - 3, "R3", "broken key leaves count", n, period_of(0, 0) - 3);

    // R10 disable holds, re-enable counts full period
    do_ack();
    service();
    repeat (8) @(posedge clk);
    bus_wr(1'b0, 8'h00);
    repeat (30) @(posedge clk);
    #1 check(irq == 1'b0, "R10", "no expiry while disabled", irq, 0);
    bus_wr(1'b0, 8'h80);
    wait_event(5000, n, gi, gr);
    check(gi && n == period_of(0, 0), "R10", "full period after re-enable", n, period_of(0, 0));

    // R8 soft-reset action
    do_ack();
    bus_wr(1'b0, 8'h00);
    bus_wr(1'b0, 8'hC8);
    service();
    wait_event(5000, n, gi, gr);
    check(gr && !gi && n == period_of(0, 1), "R8", "soft reset timing", n, period_of(0, 1));
    @(posedge clk); #1;
    check(soft_reset == 1'b0, "R8", "pulse is one cycle", soft_reset, 0);
    read_reg(1'b0, v);
    check(v == 8'h00, "R8", "ctrl cleared by soft reset", v, 0);
    bus_wr(1'b0, 8'h98);
    wait_event(5000, n, gi, gr);
    check(gi && n == period_of(0, 0), "R8", "shortest period after soft reset", n, period_of(0, 0));
    do_ack();

    // R4 R5 R11 random settings with directed prescaled corners first
    for (int i = 0; i < 10; i++) begin
      bit pre;
      int sel;
      logic [7:0] c;
      int p;
      pre = (i < 2) ? 1'b1 : 1'($urandom % 2);
      sel = (i == 0) ? 3 : (i == 1) ? 0 : int'($urandom % 4);
      c = 8'h80 | (8'(pre) << 5) | (8'(sel) << 3) | 8'($urandom % 8);
      p = period_of(pre, sel);
      if (irq) do_ack();
      bus_wr(1'b0, 8'h00);
      bus_wr(1'b0, c);
      read_reg(1'b0, v);
      check(v == c, "R11", "ctrl readback with spare bits", v, c);
      service();
      wait_event(p + 10, n, gi, gr);
      check(gi && n == p, pre ? "R5" : "R4", "random period", n, p);
      do_ack();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule